// File: doc/BRIEF.md
# QoS Priority Arbiter with Least-Recently-Granted Tie Break

This block decides which of several bus masters gets the next slot on one shared slave port. Each master raises a request with a 4-bit priority value. The arbiter grants the request with the largest effective priority. When several requests share that largest value, the arbiter grants the one that was served longest ago. For each channel, a mode input selects where priorities come from. In dynamic mode, the value each master drives is used. In static mode, a fixed per-port value is used and the master's value is ignored.

Read and write requests are arbitrated by two separate, identical channels. Each channel has its own mode input, its own fixed priorities and its own grant history. Once a winner is shown on the slave side, the grant stays fixed until the slave accepts it with ready. Each channel also produces a one-bit urgent flag for a memory-controller port. A shared three-way selector picks the flag's source:

- the top bit of the granted request's effective priority,
- a configuration bit, or
- an external pin.

Top module: `qos_lrg_arbiter`

## Requirements
- R1: The grant goes to a requesting port whose effective priority is the largest among all requesting ports; priority 15 is highest and 0 lowest.
- R2: Among requesting ports tied at the largest priority, the least recently granted one wins. After reset the history ranks port 0 as least recent, then 1, 2, 3. So four equal requesters held high are granted 0, 1, 2, 3, 0 on successive accepts. An accepted port moves to the most-recent end of the history.
- R3: With a channel's static-mode input high, port i's priority is bits [4i+3:4i] of that channel's fixed-priority input, and the port's own priority bits have no effect on the grant.
- R4: With the static-mode input low, port i's priority is bits [4i+3:4i] of the channel's request-priority input.
- R5: While the slave-side valid is high and ready is low, the granted port index and grant vector stay unchanged, even if a higher-priority request arrives.
- R6: The grant vector has at most one bit set, bit i meaning port i. Valid is high exactly when a grant bit is set, and a new grant only goes to a requesting port.
- R7: With urgent-source select 0, a channel's urgent output equals bit 3 of the granted port's effective priority, and 0 when the channel has no grant.
- R8: Urgent-source select 1 drives both urgent outputs from the configuration bit, select 2 from the external pin, and select 3 forces both to 0.
- R9: The read and write channels keep separate grant histories, and traffic on one leaves the other's grant unchanged.
- R10: After reset neither channel shows a grant or valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | NPORT | Read request per port |
| rd_qos | input | 4*NPORT | Read request priority, 4 bits per port |
| rd_static_en | input | 1 | Read channel uses fixed priorities |
| rd_static_prio | input | 4*NPORT | Read channel fixed priority per port |
| rd_ready | input | 1 | Slave accepts the read grant |
| rd_gnt | output | NPORT | Read grant, one-hot |
| rd_valid | output | 1 | Read grant present |
| rd_port | output | log2(NPORT) | Index of granted read port |
| rd_urgent | output | 1 | Read urgent flag to memory port |
| wr_req | input | NPORT | Write request per port |
| wr_qos | input | 4*NPORT | Write request priority, 4 bits per port |
| wr_static_en | input | 1 | Write channel uses fixed priorities |
| wr_static_prio | input | 4*NPORT | Write channel fixed priority per port |
| wr_ready | input | 1 | Slave accepts the write grant |
| wr_gnt | output | NPORT | Write grant, one-hot |
| wr_valid | output | 1 | Write grant present |
| wr_port | output | log2(NPORT) | Index of granted write port |
| wr_urgent | output | 1 | Write urgent flag to memory port |
| urg_src | input | 2 | Urgent source: 0 priority MSB, 1 config bit, 2 pin, 3 off |
| urg_cfg | input | 1 | Configuration urgent bit |
| urg_pin | input | 1 | External urgent pin |

## Verification
The hold checks assume that masters follow the usual valid rule. A request, once raised, stays high with a steady priority until its grant is accepted. The stimulus therefore only adds new requesters during a stall and never withdraws the held one. The stimulus also changes mode and fixed-priority inputs only while the affected channel is idle or accepting every cycle, so that stalled grants never see their effective priority move under them.

// File: rtl/qos_arb_pkg.sv
package qos_arb_pkg;

    localparam int PRIO_W = 4;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic [1:0] {
        URG_FROM_PRIO = 2'd0,
        URG_FROM_CFG  = 2'd1,
        URG_FROM_PIN  = 2'd2,
        URG_FORCE_OFF = 2'd3
    } urg_src_e;

    typedef struct packed {
        urg_src_e src;
        logic     cfg_bit;
        logic     ext_pin;
    } urg_cfg_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/qos_eff_sel.sv
module qos_eff_sel
    import qos_arb_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  logic [PRIO_W*NPORT-1:0] dyn_prio_i,
    input  logic [PRIO_W*NPORT-1:0] fix_prio_i,
    input  logic                    static_en_i,
    output prio_t                   eff_o [NPORT]
);

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        always_comb begin
            if (static_en_i)
                eff_o[g] = fix_prio_i[g*PRIO_W +: PRIO_W];
            else
                eff_o[g] = dyn_prio_i[g*PRIO_W +: PRIO_W];
        end
    end

endmodule

// File: rtl/qos_lrg_core.sv
module qos_lrg_core
    import qos_arb_pkg::*;
#(
    parameter  int NPORT = 4,
    localparam int IDX_W = idx_width(NPORT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] req_i,
    input  prio_t            eff_i [NPORT],
    input  logic             ready_i,
    output logic [NPORT-1:0] gnt_o,
    output logic             valid_o,
    output logic [IDX_W-1:0] port_o
);

    // history: slot 0 = least recently granted
    logic [IDX_W-1:0] hist_q [NPORT];
    logic [IDX_W-1:0] hist_d [NPORT];
    logic             busy_q;
    logic [IDX_W-1:0] held_q;

    prio_t            top_prio;
    logic [IDX_W-1:0] win_idx;
    logic [IDX_W-1:0] sel_idx;
    int unsigned      sel_slot;
    logic             accept;

    // level 1: largest effective priority among requesters
    always_comb begin
        top_prio = '0;
        for (int i = 0; i < NPORT; i++)
            if (req_i[i] && eff_i[i] > top_prio)
                top_prio = eff_i[i];
    end

    // level 2: first entry of the history that requests at that priority
    always_comb begin
        logic found;
        found   = 1'b0;
        win_idx = '0;
        for (int s = 0; s < NPORT; s++) begin
            if (!found && req_i[hist_q[s]] && eff_i[hist_q[s]] == top_prio) begin
                found   = 1'b1;
                win_idx = hist_q[s];
            end
        end
    end

    assign sel_idx = busy_q ? held_q : win_idx;
    assign valid_o = busy_q | (|req_i);
    assign port_o  = sel_idx;
    assign accept  = valid_o & ready_i;

    always_comb begin
        gnt_o          = '0;
        gnt_o[sel_idx] = valid_o;
    end

    // move the served port to the most-recent end
    always_comb begin
        sel_slot = 0;
        for (int s = 0; s < NPORT; s++)
            if (hist_q[s] == sel_idx)
                sel_slot = s;
        for (int s = 0; s < NPORT - 1; s++)
            hist_d[s] = (s < sel_slot) ? hist_q[s] : hist_q[s+1];
        hist_d[NPORT-1] = sel_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            held_q <= '0;
            for (int s = 0; s < NPORT; s++)
                hist_q[s] <= IDX_W'(s);
        end else begin
            if (accept) begin
                busy_q <= 1'b0;
                for (int s = 0; s < NPORT; s++)
                    hist_q[s] <= hist_d[s];
            end else if (valid_o && !busy_q) begin
                busy_q <= 1'b1;
                held_q <= win_idx;
            end
        end
    end

    // R6
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_o));

    // R6
    gnt_valid_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o == (|gnt_o));

    // R6
    gnt_to_req_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !busy_q) |-> ((gnt_o & req_i) != '0));

    // R5
    hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !ready_i) |=> (valid_o && $stable(port_o) && $stable(gnt_o)));

endmodule

// File: rtl/qos_urg_mux.sv
module qos_urg_mux
    import qos_arb_pkg::*;
(
    input  urg_cfg_t cfg_i,
    input  logic     prio_msb_i,
    output logic     urgent_o
);

    always_comb begin
        unique case (cfg_i.src)
            URG_FROM_PRIO: urgent_o = prio_msb_i;
            URG_FROM_CFG:  urgent_o = cfg_i.cfg_bit;
            URG_FROM_PIN:  urgent_o = cfg_i.ext_pin;
            default:       urgent_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/qos_chan.sv
module qos_chan
    import qos_arb_pkg::*;
#(
    parameter  int NPORT = 4,
    localparam int IDX_W = idx_width(NPORT)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPORT-1:0]        req_i,
    input  logic [PRIO_W*NPORT-1:0] qos_i,
    input  logic                    static_en_i,
    input  logic [PRIO_W*NPORT-1:0] static_prio_i,
    input  logic                    ready_i,
    input  urg_cfg_t                urg_i,
    output logic [NPORT-1:0]        gnt_o,
    output logic                    valid_o,
    output logic [IDX_W-1:0]        port_o,
    output logic                    urgent_o
);

    prio_t eff [NPORT];
    logic  gnt_msb;

    qos_eff_sel #(.NPORT(NPORT)) u_eff (
        .dyn_prio_i  (qos_i),
        .fix_prio_i  (static_prio_i),
        .static_en_i (static_en_i),
        .eff_o       (eff)
    );

    qos_lrg_core #(.NPORT(NPORT)) u_core (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req_i),
        .eff_i   (eff),
        .ready_i (ready_i),
        .gnt_o   (gnt_o),
        .valid_o (valid_o),
        .port_o  (port_o)
    );

    assign gnt_msb = valid_o & eff[port_o][PRIO_W-1];

    qos_urg_mux u_urg (
        .cfg_i      (urg_i),
        .prio_msb_i (gnt_msb),
        .urgent_o   (urgent_o)
    );

endmodule

// File: rtl/qos_lrg_arbiter.sv
module qos_lrg_arbiter
    import qos_arb_pkg::*;
#(
    parameter  int NPORT = 4,
    localparam int IDX_W = idx_width(NPORT),
    localparam int PV_W  = PRIO_W * NPORT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] rd_req,
    input  logic [PV_W-1:0]  rd_qos,
    input  logic             rd_static_en,
    input  logic [PV_W-1:0]  rd_static_prio,
    input  logic             rd_ready,
    output logic [NPORT-1:0] rd_gnt,
    output logic             rd_valid,
    output logic [IDX_W-1:0] rd_port,
    output logic             rd_urgent,
    input  logic [NPORT-1:0] wr_req,
    input  logic [PV_W-1:0]  wr_qos,
    input  logic             wr_static_en,
    input  logic [PV_W-1:0]  wr_static_prio,
    input  logic             wr_ready,
    output logic [NPORT-1:0] wr_gnt,
    output logic             wr_valid,
    output logic [IDX_W-1:0] wr_port,
    output logic             wr_urgent,
    input  logic [1:0]       urg_src,
    input  logic             urg_cfg,
    input  logic             urg_pin
);

    urg_cfg_t urg;

    assign urg.src     = urg_src_e'(urg_src);
    assign urg.cfg_bit = urg_cfg;
    assign urg.ext_pin = urg_pin;

    qos_chan #(.NPORT(NPORT)) u_rd (
        .clk           (clk),
        .rst           (rst),
        .req_i         (rd_req),
        .qos_i         (rd_qos),
        .static_en_i   (rd_static_en),
        .static_prio_i (rd_static_prio),
        .ready_i       (rd_ready),
        .urg_i         (urg),
        .gnt_o         (rd_gnt),
        .valid_o       (rd_valid),
        .port_o        (rd_port),
        .urgent_o      (rd_urgent)
    );

    qos_chan #(.NPORT(NPORT)) u_wr (
        .clk           (clk),
        .rst           (rst),
        .req_i         (wr_req),
        .qos_i         (wr_qos),
        .static_en_i   (wr_static_en),
        .static_prio_i (wr_static_prio),
        .ready_i       (wr_ready),
        .urg_i         (urg),
        .gnt_o         (wr_gnt),
        .valid_o       (wr_valid),
        .port_o        (wr_port),
        .urgent_o      (wr_urgent)
    );

    // R8
    urg_shared_chk: assert property (@(posedge clk) disable iff (rst)
        (urg_src != 2'd0) |-> (rd_urgent == wr_urgent));

    // R7
    urg_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (urg_src == 2'd0 && !rd_valid) |-> !rd_urgent);

endmodule

// File: tb/qos_lrg_arbiter_bench.sv
`timescale 1ns/1ps
module qos_lrg_arbiter_bench;

    localparam int NP = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rd_req = '0, wr_req = '0;
    logic [15:0] rd_qos = '0, wr_qos = '0;
    logic        rd_static_en = 1'b0, wr_static_en = 1'b0;
    logic [15:0] rd_static_prio = '0, wr_static_prio = '0;
    logic        rd_ready = 1'b0, wr_ready = 1'b0;
    logic [3:0]  rd_gnt, wr_gnt;
    logic        rd_valid, wr_valid;
    logic [1:0]  rd_port, wr_port;
    logic        rd_urgent, wr_urgent;
    logic [1:0]  urg_src = 2'd0;
    logic        urg_cfg = 1'b0, urg_pin = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int rd_q [$];
    int wr_q [$];

    always #10 clk = ~clk;

    qos_lrg_arbiter #(.NPORT(NP)) u_qos_lrg_arbiter (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic mid();
        @(negedge clk); #1;
    endtask

    task automatic rd_issue(input logic [3:0] r, input logic [15:0] q, input int exp);
        step();
        rd_req = r; rd_qos = q; rd_ready = 1'b1;
        rd_q.push_back(exp);
    endtask

    task automatic wr_issue(input logic [3:0] r, input logic [15:0] q, input int exp);
        step();
        wr_req = r; wr_qos = q; wr_ready = 1'b1;
        wr_q.push_back(exp);
    endtask

    task automatic rd_idle();
        step();
        rd_req = '0; rd_ready = 1'b0;
    endtask

    task automatic wr_idle();
        step();
        wr_req = '0; wr_ready = 1'b0;
    endtask

    // scoreboard monitor: every accepted grant is compared with the queue head
    always @(negedge clk) begin
        if (!rst && rd_valid && rd_ready) begin
            if (rd_q.size() == 0) check(1'b0, "R1 rd unexpected accept", rd_port, -1);
            else begin
                int e;
                e = rd_q.pop_front();
                check(rd_port == e && rd_gnt == (4'b1 << e), "R1/R2 rd grant", rd_port, e);
            end
        end
        if (!rst && wr_valid && wr_ready) begin
            if (wr_q.size() == 0) check(1'b0, "R1 wr unexpected accept", wr_port, -1);
            else begin
                int e;
                e = wr_q.pop_front();
                check(wr_port == e && wr_gnt == (4'b1 << e), "R2/R9 wr grant", wr_port, e);
            end
        end
    end

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        mid();
        // R10
        check(!rd_valid && rd_gnt == 0, "R10 rd idle after reset", rd_gnt, 0);
        check(!wr_valid && wr_gnt == 0, "R10 wr idle after reset", wr_gnt, 0);
        check(!rd_urgent, "R7 urgent low with no grant", rd_urgent, 0);

        // R2: equal priorities rotate 0,1,2,3,0
        rd_issue(4'hF, 16'h5555, 0);
        rd_issue(4'hF, 16'h5555, 1);
        rd_issue(4'hF, 16'h5555, 2);
        rd_issue(4'hF, 16'h5555, 3);
        rd_issue(4'hF, 16'h5555, 0);
        // R1: highest wins, tie to least recent
        rd_issue(4'hF, 16'h1993, 1);
        rd_issue(4'hF, 16'h1993, 2);
        rd_issue(4'hF, 16'hF993, 3);
        rd_issue(4'h1, 16'h0000, 0);
        rd_idle();

        // R3: static mode ignores request priority
        rd_static_en = 1'b1;
        rd_static_prio = 16'h2C22;
        rd_issue(4'hF, 16'hF0FF, 2);
        step(); rd_static_prio = 16'h1117; rd_qos = 16'hFFF0; rd_q.push_back(0);
        step(); rd_static_prio = 16'h4444; rd_qos = 16'h1234; rd_q.push_back(1);
        rd_idle();

        // R4: dynamic mode uses request priority, fixed values ignored
        step();
        rd_static_en = 1'b0;
        rd_static_prio = 16'h000F;
        rd_issue(4'hF, 16'h2E22, 2);
        rd_idle();

        // R5: stall holds the grant
        step();
        rd_req = 4'b0011; rd_qos = 16'h0066; rd_ready = 1'b0;
        mid();
        check(rd_valid && rd_port == 0, "R5 rd stall winner", rd_port, 0);
        step();
        rd_req = 4'b1011; rd_qos = 16'hF066;
        mid();
        check(rd_valid && rd_port == 0 && rd_gnt == 4'b0001, "R5 rd held during stall", rd_port, 0);
        step();
        rd_ready = 1'b1; rd_q.push_back(0);
        rd_issue(4'b1011, 16'hF066, 3);
        rd_idle();

        // R9: read stalled on port 1 while write rotates from its own fresh history
        step();
        rd_req = 4'b0010; rd_qos = 16'h0010; rd_ready = 1'b0;
        wr_issue(4'hF, 16'h3333, 0);
        mid();
        check(rd_port == 1 && rd_valid, "R9 rd unaffected by wr", rd_port, 1);
        wr_issue(4'hF, 16'h3333, 1);
        mid();
        check(rd_port == 1 && rd_valid, "R9 rd unaffected by wr", rd_port, 1);
        wr_idle();
        step(); rd_ready = 1'b1; rd_q.push_back(1);
        rd_idle();

        // R7: urgent from granted priority MSB
        urg_src = 2'd0;
        wr_issue(4'b0100, 16'h0800, 2);
        mid();
        check(wr_urgent == 1'b1, "R7 urgent from MSB set", wr_urgent, 1);
        wr_issue(4'b0100, 16'h0700, 2);
        mid();
        check(wr_urgent == 1'b0, "R7 urgent from MSB clear", wr_urgent, 0);
        wr_idle();
        mid();
        check(wr_urgent == 1'b0, "R7 urgent idle", wr_urgent, 0);
        step();
        wr_static_en = 1'b1; wr_static_prio = 16'h0090;
        wr_issue(4'b0010, 16'h0000, 1);
        mid();
        check(wr_urgent == 1'b1, "R7 urgent from static priority", wr_urgent, 1);
        wr_idle();
        step(); wr_static_en = 1'b0;

        // R8: other urgent sources
        step(); urg_src = 2'd1; urg_cfg = 1'b1; urg_pin = 1'b0;
        mid();
        check(rd_urgent && wr_urgent, "R8 cfg bit high", {rd_urgent, wr_urgent}, 3);
        step(); urg_cfg = 1'b0; urg_pin = 1'b1;
        mid();
        check(!rd_urgent && !wr_urgent, "R8 cfg bit low", {rd_urgent, wr_urgent}, 0);
        step(); urg_src = 2'd2;
        mid();
        check(rd_urgent && wr_urgent, "R8 pin high", {rd_urgent, wr_urgent}, 3);
        step(); urg_src = 2'd3; urg_cfg = 1'b1;
        mid();
        check(!rd_urgent && !wr_urgent, "R8 forced off", {rd_urgent, wr_urgent}, 0);

        step();
        check(rd_q.size() == 0, "R1 rd queue drained", rd_q.size(), 0);
        check(wr_q.size() == 0, "R2 wr queue drained", wr_q.size(), 0);
        done = 1'b1;
        report();
    end

endmodule